// File: doc/BRIEF.md
# Four-Phase Handshake Register Slave

This block is a small register-file slave for a simple synchronous on-chip register bus. The master presents a word address, a read/write flag and write data. It then raises a select line and holds it until the slave answers with an acknowledge. The acknowledge stays high until the master drops select, which gives a four-phase handshake. Because of this the master may run on an unrelated clock. Select is passed through a configurable synchronizer before the slave acts on it.

The slave holds two configuration bits for a framing datapath: a scrambler enable and a check-sequence width select. It also holds a set of sticky event flags and an interrupt mask. Datapath logic raises event pulses that set the flags. Software clears a flag by writing a one to its bit. The interrupt output is high whenever any flag is set and its mask bit is also set.

While select is low, read data and acknowledge are held at zero. This lets several slaves share one return path through a plain OR gate.

Top module: `regslv_top`

## Requirements
- R1: After reset, all configuration, mask and flag bits are zero. The `dtack`, `rdata` and `irq` outputs are also zero.
- R2: Once `sel` rises, `dtack` rises on the (SYNC_STAGES+2)-th rising clock edge. It then stays high for as long as `sel` stays high.
- R3: Whenever `sel` is low, `dtack` and `rdata` are zero, without waiting for a clock edge.
- R4: Word address 0 is the configuration register. Bit 0 is the scrambler enable (`cfg_scr_en`) and bit 1 selects the 32-bit check sequence (`cfg_fcs32`). Both bits read back; all higher bits read as zero.
- R5: Word address 2 is the interrupt mask. Its low STAT_W bits are read/write and the higher bits read as zero.
- R6: Word address 1 holds the event flags. A one on bit i of `status_set` for one clock sets flag i, and the flag stays set until it is cleared.
- R7: A write to address 1 clears exactly the flags whose write-data bit is one. A write of zeros changes nothing. If a set pulse and a clear of the same flag land in the same cycle, the set wins.
- R8: `irq` is high exactly when some flag bit and the same mask bit are both one.
- R9: Addresses 3 to 15 are acknowledged like any other access, read as zero, and writes to them change no register.
- R10: Each handshake performs exactly one access. If `sel` is held high after the acknowledge, the access is not repeated. For example, a flag set during the hold phase of a clearing write stays set.
- R11: Once acknowledged, `rdata` keeps the value captured at the access, even if `addr` or `read` change while `sel` is still high. A new access starts only after `sel` has been seen low.
- R12: Reads have no side effects. Reading the flag register leaves the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slave clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel | input | 1 | Access select from the master; may be asynchronous |
| read | input | 1 | 1 = read, 0 = write; held stable by the master while selected |
| addr | input | ADDR_W (4) | Word address |
| wdata | input | DATA_W (16) | Write data |
| rdata | output | DATA_W (16) | Read data; zero unless acknowledging |
| dtack | output | 1 | Acknowledge; high from completion until `sel` drops |
| status_set | input | STAT_W (8) | One-cycle pulses that set event flags |
| cfg_scr_en | output | 1 | Scrambler enable bit |
| cfg_fcs32 | output | 1 | Check-sequence width select (1 = 32-bit) |
| irq | output | 1 | Interrupt request: OR of flags masked by the mask register |

## Verification
The bench builds the slave with STAT_W = 6 and the default two-stage synchronizer. The narrower flag width makes the read-back truncation of the mask and flag registers visible with an all-ones write. The synchronizer depth sets the exact acknowledge latency, so the bench can time a set pulse to land in the very cycle of a clearing write. It can also place a second pulse inside the hold phase. Each of those two cases exposes its own failure: a wrong set/clear priority, or an access that repeats while select is held.

// File: rtl/regslv_pkg.sv
package regslv_pkg;

    typedef enum logic [1:0] {
        HS_IDLE = 2'd0,
        HS_ACC  = 2'd1,
        HS_HOLD = 2'd2
    } hs_state_e;

    localparam int ADDR_CFG  = 0;
    localparam int ADDR_FLAG = 1;
    localparam int ADDR_MASK = 2;

endpackage

// File: rtl/regslv_sync.sv
module regslv_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign q_o = sh_q[STAGES-1];

    initial begin
        if (STAGES < 2) $error("regslv_sync needs at least two stages");
    end
endmodule

// File: rtl/regslv_hs.sv
module regslv_hs
    import regslv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel_s_i,
    output logic acc_o,
    output logic hold_o
);
    typedef struct packed {
        hs_state_e st;
    } hs_t;

    hs_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            HS_IDLE: if (sel_s_i)  s_d.st = HS_ACC;
            HS_ACC:                s_d.st = HS_HOLD;
            HS_HOLD: if (!sel_s_i) s_d.st = HS_IDLE;
            default:               s_d.st = HS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: HS_IDLE};
        else        s_q <= s_d;
    end

    assign acc_o  = (s_q.st == HS_ACC);
    assign hold_o = (s_q.st == HS_HOLD);

    // R10: an access strobe never repeats back to back
    p_single_access_r10: assert property (@(posedge clk) disable iff (!rst_n)
        acc_o |=> !acc_o);

    // R2: acknowledge phase persists while the synchronized select stays high
    p_hold_until_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_o && sel_s_i) |=> hold_o);

    // R11: a new access only follows a cycle outside the hold phase
    p_start_after_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        acc_o |-> !$past(hold_o));
endmodule

// File: rtl/regslv_regs.sv
module regslv_regs
    import regslv_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4,
    parameter int STAT_W = 8,
    parameter int CFG_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [STAT_W-1:0] set_i,
    output logic [DATA_W-1:0] rword_o,
    output logic [CFG_W-1:0]  cfg_o,
    output logic              irq_o
);
    localparam int CFG_PAD  = DATA_W - CFG_W;
    localparam int STAT_PAD = DATA_W - STAT_W;

    typedef struct packed {
        logic [CFG_W-1:0]  cfg;
        logic [STAT_W-1:0] mask;
        logic [STAT_W-1:0] flag;
    } regs_t;

    regs_t r_d, r_q;

    logic              wr_cfg, wr_flag, wr_mask;
    logic [STAT_W-1:0] clr;

    always_comb begin
        wr_cfg  = acc_i && !rd_i && (addr_i == ADDR_W'(ADDR_CFG));
        wr_flag = acc_i && !rd_i && (addr_i == ADDR_W'(ADDR_FLAG));
        wr_mask = acc_i && !rd_i && (addr_i == ADDR_W'(ADDR_MASK));
        clr     = wr_flag ? wdata_i[STAT_W-1:0] : '0;

        r_d = r_q;
        if (wr_cfg)  r_d.cfg  = wdata_i[CFG_W-1:0];
        if (wr_mask) r_d.mask = wdata_i[STAT_W-1:0];
        r_d.flag = (r_q.flag & ~clr) | set_i;

        unique case (addr_i)
            ADDR_W'(ADDR_CFG):  rword_o = {{CFG_PAD{1'b0}}, r_q.cfg};
            ADDR_W'(ADDR_FLAG): rword_o = {{STAT_PAD{1'b0}}, r_q.flag};
            ADDR_W'(ADDR_MASK): rword_o = {{STAT_PAD{1'b0}}, r_q.mask};
            default:            rword_o = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cfg_o = r_q.cfg;
    assign irq_o = |(r_q.flag & r_q.mask);

    // R6/R7: a set pulse always leaves its flag set, even against a clear
    p_sticky_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((r_q.flag & $past(set_i)) == $past(set_i)));

    // R8: no interrupt while every mask bit is clear
    p_irq_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.mask == '0) |-> !irq_o);

    // R9: unmapped writes leave configuration and mask untouched
    p_unmapped_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_i && !rd_i && addr_i > ADDR_W'(ADDR_MASK)) |=>
            ($stable(r_q.cfg) && $stable(r_q.mask)));

    // R12: a read never alters the flags without a set pulse
    p_read_no_side_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_i && rd_i && set_i == '0) |=> $stable(r_q.flag));

    initial begin
        if (STAT_W > DATA_W || CFG_W > DATA_W || CFG_W < 2)
            $error("regslv_regs parameter range");
    end
endmodule

// File: rtl/regslv_top.sv
module regslv_top
    import regslv_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int ADDR_W      = 4,
    parameter int STAT_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              read,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              dtack,
    input  logic [STAT_W-1:0] status_set,
    output logic              cfg_scr_en,
    output logic              cfg_fcs32,
    output logic              irq
);
    localparam int CFG_W = 2;

    typedef struct packed {
        logic [DATA_W-1:0] rdat;
    } top_t;

    top_t t_d, t_q;

    logic              sel_s, acc, hold;
    logic [DATA_W-1:0] rword;
    logic [CFG_W-1:0]  cfg;

    regslv_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (sel),
        .q_o   (sel_s)
    );

    regslv_hs u_hs (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_s_i (sel_s),
        .acc_o   (acc),
        .hold_o  (hold)
    );

    regslv_regs #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .STAT_W (STAT_W),
        .CFG_W  (CFG_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc_i   (acc),
        .rd_i    (read),
        .addr_i  (addr),
        .wdata_i (wdata),
        .set_i   (status_set),
        .rword_o (rword),
        .cfg_o   (cfg),
        .irq_o   (irq)
    );

    always_comb begin
        t_d = t_q;
        if (acc) t_d.rdat = read ? rword : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign dtack      = hold && sel;
    assign rdata      = dtack ? t_q.rdat : '0;
    assign cfg_scr_en = cfg[0];
    assign cfg_fcs32  = cfg[1];

    // R3: deselected slave drives nothing onto the OR-merged return path
    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |-> (!dtack && rdata == '0));

    // R11: captured read data does not move during the hold phase
    p_rdata_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (dtack && $past(dtack)) |-> $stable(rdata));
endmodule

// File: tb/regslv_top_tb.sv
module regslv_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int STW        = 6;
    localparam int SYNC       = 2;
    localparam int LAT        = SYNC + 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            sel = 1'b0;
    logic            rdn = 1'b0;
    logic [3:0]      addr = '0;
    logic [15:0]     wdata = '0;
    logic [15:0]     rdata;
    logic            dtack;
    logic [STW-1:0]  status_set = '0;
    logic            cfg_scr_en, cfg_fcs32, irq;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    typedef struct {
        logic        is_rd;
        logic [15:0] val;
        int          req;
    } exp_t;
    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    regslv_top #(.DATA_W(16), .ADDR_W(4), .STAT_W(STW), .SYNC_STAGES(SYNC)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel        (sel),
        .read       (rdn),
        .addr       (addr),
        .wdata      (wdata),
        .rdata      (rdata),
        .dtack      (dtack),
        .status_set (status_set),
        .cfg_scr_en (cfg_scr_en),
        .cfg_fcs32  (cfg_fcs32),
        .irq        (irq)
    );

    task automatic chk(input bit ok, input int req, input string what,
                       input logic [15:0] act, input logic [15:0] expv);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    // monitor: pops one scoreboard entry per acknowledge rising edge
    logic dtack_prev = 1'b0;
    always @(negedge clk) begin
        if (dtack && !dtack_prev) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, 2, "unexpected acknowledge", 16'h1, 16'h0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (e.is_rd) chk(rdata == e.val, e.req, "read data", rdata, e.val);
            end
        end
        dtack_prev = dtack;
    end

    // driver: one full four-phase transfer; acc_p lands in the access cycle,
    // hold_p lands one cycle into the hold phase
    task automatic xfer(input logic rd, input logic [3:0] a, input logic [15:0] wd,
                        input logic [15:0] expv, input int req,
                        input logic [STW-1:0] acc_p, input logic [STW-1:0] hold_p);
        int n;
        n = 0;
        exp_q.push_back('{rd, expv, req});
        @(negedge clk);
        sel = 1'b1; rdn = rd; addr = a; wdata = wd;
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            status_set = (k == LAT-1) ? acc_p : '0;
            if (dtack) begin n = k; break; end
        end
        // R2: acknowledge latency
        chk(n == LAT, 2, "ack latency", 16'(n), 16'(LAT));
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            status_set = (k == 1) ? hold_p : '0;
            addr  = a ^ 4'h1;
            wdata = ~wd;
            rdn   = ~rd;
            chk(dtack == 1'b1, 2, "ack held", 16'(dtack), 16'h1);
            if (rd) chk(rdata == expv, 11, "rdata held", rdata, expv); // R11
        end
        status_set = '0;
        sel = 1'b0;
        #1;
        // R3: outputs drop as soon as select drops
        chk(dtack == 1'b0 && rdata == 16'h0, 3, "idle outputs", {dtack, rdata[14:0]}, 16'h0);
        rdn = rd; addr = a;
        repeat (LAT + 1) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d, input int req);
        xfer(1'b0, a, d, 16'h0, req, '0, '0);
    endtask

    task automatic rd(input logic [3:0] a, input logic [15:0] e, input int req);
        xfer(1'b1, a, 16'h0, e, req, '0, '0);
    endtask

    task automatic pulse(input logic [STW-1:0] m);
        @(negedge clk); status_set = m;
        @(negedge clk); status_set = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            chk(1'b0, 0, "watchdog expired", 16'h0, 16'h1);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(dtack == 0 && rdata == 0, 1, "reset bus outputs", rdata, 16'h0);
        chk(irq == 0 && cfg_scr_en == 0 && cfg_fcs32 == 0, 1, "reset side outputs",
            {irq, cfg_scr_en, cfg_fcs32}, 16'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        rd(4'd0, 16'h0000, 1);
        rd(4'd1, 16'h0000, 1);
        rd(4'd2, 16'h0000, 1);

        // R4: configuration bits and read-back truncation
        wr(4'd0, 16'hFFFF, 4);
        chk(cfg_scr_en && cfg_fcs32, 4, "cfg outputs all ones", {cfg_fcs32, cfg_scr_en}, 16'h3);
        rd(4'd0, 16'h0003, 4);
        wr(4'd0, 16'h0002, 4);
        chk(!cfg_scr_en && cfg_fcs32, 4, "cfg outputs fcs32 only", {cfg_fcs32, cfg_scr_en}, 16'h2);
        rd(4'd0, 16'h0002, 4);

        // R5: mask width
        wr(4'd2, 16'hFFFF, 5);
        rd(4'd2, 16'h003F, 5);
        wr(4'd2, 16'h0000, 5);

        // R6 / R12: sticky flags, reads leave them alone
        pulse(6'h05);
        rd(4'd1, 16'h0005, 6);
        rd(4'd1, 16'h0005, 12);
        chk(irq == 0, 8, "irq with empty mask", 16'(irq), 16'h0);

        // R8 / R7: masked interrupt and write-one-to-clear
        wr(4'd2, 16'h0004, 8);
        chk(irq == 1, 8, "irq on masked flag", 16'(irq), 16'h1);
        wr(4'd1, 16'h0004, 7);
        rd(4'd1, 16'h0001, 7);
        chk(irq == 0, 8, "irq after clear", 16'(irq), 16'h0);
        wr(4'd1, 16'h0000, 7);
        rd(4'd1, 16'h0001, 7);

        // R7: set and clear of the same flag in the access cycle, set wins
        xfer(1'b0, 4'd1, 16'h0001, 16'h0, 7, 6'h01, '0);
        rd(4'd1, 16'h0001, 7);

        // R10: flag set during hold of a clearing write must survive
        xfer(1'b0, 4'd1, 16'h0001, 16'h0, 10, '0, 6'h01);
        rd(4'd1, 16'h0001, 10);
        wr(4'd1, 16'h0001, 10);
        rd(4'd1, 16'h0000, 10);

        // R9: unmapped space
        wr(4'd5, 16'hFFFF, 9);
        wr(4'd15, 16'hFFFF, 9);
        rd(4'd5, 16'h0000, 9);
        rd(4'd15, 16'h0000, 9);
        rd(4'd0, 16'h0002, 9);
        rd(4'd2, 16'h0004, 9);

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, 2, "scoreboard drained", 16'(exp_q.size()), 16'h0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule